// File: doc/BRIEF.md
# Frame Alignment Error-Rate Alarm

This block supervises the quality of a framed receive stream. Each time the upstream framer judges a received alignment word to be wrong, it pulses an error strobe. The block counts these pulses inside consecutive two-second observation windows. It drives an alarm flag that changes state only after two back-to-back windows agree.

Two small codes set the thresholds. A 4-bit raise code selects how many errors in a window arm the alarm. A 3-bit clear code selects the error count at or under which a window counts as healthy. Both codes use non-linear steps, and the two thresholds give the flag hysteresis. If the decoded clear level lies above the raise level, the clear level is ignored. In that case a window counts as healthy whenever it stays under the raise level. An external timer supplies a one-cycle tick at every window boundary.

Top module: `fae_alarm`

## Requirements
- R1: After synchronous reset the alarm output is 0 and no earlier window counts toward a confirmation. A single bad window after reset leaves the alarm at 0.
- R2: The window count includes every cycle with `fa_err` high since the previous tick, including the tick cycle itself.
- R3: The window count saturates at 2^CNT_W-1 (127 by default) instead of wrapping. With raise code 15, a window of 130 errors still counts as bad.
- R4: The raise code k decodes to 16+2k errors for k = 0..7 and to 32+4(k-8) errors for k = 8..15. A window is bad when its count is greater than or equal to that level.
- R5: The clear code decodes, for codes 0 to 7, to 8, 9, 10, 12, 14, 16, 20 and 24 errors. A window is healthy when its count is less than or equal to that level.
- R6: The alarm rises only at a tick that closes the second of two consecutive bad windows. It is visible one cycle after that tick.
- R7: A confirmation is lost when the window that follows a qualifying window does not qualify. Two qualifying windows separated by a non-qualifying one do not change the alarm.
- R8: The alarm falls only at a tick that closes the second of two consecutive healthy windows.
- R9: When the decoded clear level is greater than the decoded raise level, a window is healthy exactly when its count is below the raise level.
- R10: The alarm changes only in the cycle after a tick, and never before two ticks have occurred since its previous change or since reset.
- R11: Each tick restarts the count at zero for the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fa_err | input | 1 | One-cycle flag: the alignment word just received was wrong |
| win_tick | input | 1 | One-cycle pulse that closes a two-second window |
| raise_code | input | 4 | Coded raise threshold (R4) |
| clear_code | input | 3 | Coded clear threshold (R5) |
| alarm | output | 1 | Error-rate alarm flag |

## Verification
A faulty window counter or threshold decoder shows up as an alarm edge one window early or late. The symptom appears one cycle after the second tick, at the latest. A lost or stuck confirmation state is also visible at the ports: the alarm flips after a single window, or never flips across a confirmed pair. The bench runs a behavioural model in step with the design and compares the alarm on every clock. A divergence is therefore reported in the cycle right after the tick that caused it.

// File: rtl/fae_pkg.sv
package fae_pkg;

    localparam int THR_W = 6;

    typedef enum logic {
        CF_IDLE  = 1'b0,
        CF_ARMED = 1'b1
    } cf_state_t;

    typedef struct packed {
        logic bad_win;
        logic good_win;
    } win_verdict_t;

    function automatic logic [THR_W-1:0] raise_level(input logic [3:0] code);
        logic [THR_W-1:0] lvl;
        if (code[3]) begin
            lvl = THR_W'(32) + THR_W'({code[2:0], 2'b00});
        end else begin
            lvl = THR_W'(16) + THR_W'({code[2:0], 1'b0});
        end
        return lvl;
    endfunction

    function automatic logic [THR_W-1:0] clear_level(input logic [2:0] code);
        logic [THR_W-1:0] lvl;
        case (code)
            3'd0:    lvl = THR_W'(8);
            3'd1:    lvl = THR_W'(9);
            3'd2:    lvl = THR_W'(10);
            3'd3:    lvl = THR_W'(12);
            3'd4:    lvl = THR_W'(14);
            3'd5:    lvl = THR_W'(16);
            3'd6:    lvl = THR_W'(20);
            default: lvl = THR_W'(24);
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/fae_win_counter.sv
module fae_win_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt_q <= '0;
        end else if (err && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fae_thresh_eval.sv
module fae_thresh_eval
    import fae_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             err,
    input  logic [3:0]       raise_code,
    input  logic [2:0]       clear_code,
    output win_verdict_t     verdict
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int PAD = CNT_W - THR_W;

    logic [CNT_W-1:0] closing;
    logic [THR_W-1:0] r_lvl, c_lvl;
    logic [CNT_W-1:0] r_ext, c_ext;
    logic             clear_ignored;

    always_comb begin
        closing = (err && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
        r_lvl   = raise_level(raise_code);
        c_lvl   = clear_level(clear_code);
        r_ext   = {{PAD{1'b0}}, r_lvl};
        c_ext   = {{PAD{1'b0}}, c_lvl};
        clear_ignored    = (c_lvl > r_lvl);
        verdict.bad_win  = (closing >= r_ext);
        verdict.good_win = clear_ignored ? (closing < r_ext) : (closing <= c_ext);
    end
endmodule

// File: rtl/fae_confirm_fsm.sv
module fae_confirm_fsm
    import fae_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  win_verdict_t verdict,
    output logic         alarm
);
    cf_state_t st_q;
    logic      qualifies;

    always_comb begin
        qualifies = alarm ? verdict.good_win : verdict.bad_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
            st_q  <= CF_IDLE;
        end else if (tick) begin
            if (!qualifies) begin
                st_q <= CF_IDLE;
            end else if (st_q == CF_ARMED) begin
                alarm <= ~alarm;
                st_q  <= CF_IDLE;
            end else begin
                st_q <= CF_ARMED;
            end
        end
    end
endmodule

// File: rtl/fae_alarm.sv
module fae_alarm
    import fae_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fa_err,
    input  logic       win_tick,
    input  logic [3:0] raise_code,
    input  logic [2:0] clear_code,
    output logic       alarm
);
    logic [CNT_W-1:0] win_cnt;
    win_verdict_t     verdict;

    fae_win_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .err   (fa_err),
        .tick  (win_tick),
        .cnt_q (win_cnt)
    );

    fae_thresh_eval #(.CNT_W(CNT_W)) u_eval (
        .cnt_q      (win_cnt),
        .err        (fa_err),
        .raise_code (raise_code),
        .clear_code (clear_code),
        .verdict    (verdict)
    );

    fae_confirm_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (win_tick),
        .verdict (verdict),
        .alarm   (alarm)
    );
endmodule

// File: rtl/fae_alarm_chk.sv
module fae_alarm_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             fa_err,
    input logic             win_tick,
    input logic             alarm,
    input logic [CNT_W-1:0] cnt_q
);
    logic [1:0] ticks_since;
    logic       alarm_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_since <= 2'd0;
            alarm_d     <= 1'b0;
        end else begin
            alarm_d <= alarm;
            if (alarm != alarm_d) begin
                ticks_since <= win_tick ? 2'd1 : 2'd0;
            end else if (win_tick && ticks_since != 2'd3) begin
                ticks_since <= ticks_since + 2'd1;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !alarm);

    assert_change_after_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (alarm != $past(alarm)) |-> $past(win_tick));

    assert_rise_confirmed_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> ($past(ticks_since) >= 2'd1));

    assert_fall_confirmed_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm) |-> ($past(ticks_since) >= 2'd1));

    assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
        win_tick |=> (cnt_q == '0));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        !win_tick |=> (cnt_q >= $past(cnt_q)));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!win_tick && !fa_err) |=> $stable(cnt_q));
endmodule

bind fae_alarm fae_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fa_err   (fa_err),
    .win_tick (win_tick),
    .alarm    (alarm),
    .cnt_q    (win_cnt)
);

// File: tb/test_fae_alarm.sv
module test_fae_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int SAT = 127;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fa_err = 1'b0;
    logic       win_tick = 1'b0;
    logic [3:0] raise_code = 4'd8;
    logic [2:0] clear_code = 3'd3;
    logic       alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int rtab[16] = '{16, 18, 20, 22, 24, 26, 28, 30, 32, 36, 40, 44, 48, 52, 56, 60};
    int ctab[8]  = '{8, 9, 10, 12, 14, 16, 20, 24};

    int m_cnt = 0;
    bit m_pend = 0;
    bit m_alarm = 0;

    fae_alarm i_fae_alarm (
        .clk        (clk),
        .rst        (rst),
        .fa_err     (fa_err),
        .win_tick   (win_tick),
        .raise_code (raise_code),
        .clear_code (clear_code),
        .alarm      (alarm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: alarm actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit e, input bit t);
        int  tot;
        int  rl;
        int  cl;
        bit  hit;
        if (t) begin
            tot = (e && m_cnt < SAT) ? m_cnt + 1 : m_cnt;
            rl = rtab[raise_code];
            cl = ctab[clear_code];
            if (m_alarm) hit = (cl > rl) ? (tot < rl) : (tot <= cl);
            else         hit = (tot >= rl);
            if (!hit) m_pend = 0;
            else if (m_pend) begin m_alarm = !m_alarm; m_pend = 0; end
            else m_pend = 1;
            m_cnt = 0;
        end else if (e && m_cnt < SAT) begin
            m_cnt++;
        end
    endtask

    task automatic cyc(input bit e, input bit t, input string tag);
        fa_err = e;
        win_tick = t;
        @(posedge clk);
        model_step(e, t);
        @(negedge clk);
        check(tag, int'(alarm), int'(m_alarm));
    endtask

    task automatic window(input int n, input bit err_on_tick, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, tag);
        cyc(1'b0, 1'b0, tag);
        cyc(1'b0, 1'b0, tag);
        cyc(err_on_tick, 1'b1, tag);
        fa_err = 1'b0;
        win_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset value", int'(alarm), 0);
        rst = 1'b0;

        // R1 / R6: one bad window is not enough (default raise 32, clear 12)
        window(32, 0, "R6 first bad window");
        check("R1 single window after reset", int'(alarm), 0);
        // R7: intervening good window drops the confirmation
        window(10, 0, "R7 break");
        window(32, 0, "R7 bad again");
        window(31, 0, "R4 below raise level");
        check("R7 broken pair", int'(alarm), 0);
        window(32, 0, "R6 pair a");
        window(32, 0, "R6 pair b");
        check("R6 confirmed raise", int'(alarm), 1);

        // R8: clearing with hysteresis at 12
        window(13, 0, "R8 above clear");
        window(12, 0, "R8 clear a");
        window(20, 0, "R7 clear broken");
        window(12, 0, "R8 clear b");
        check("R8 not yet cleared", int'(alarm), 1);
        window(12, 0, "R8 clear c");
        check("R8 confirmed clear", int'(alarm), 0);

        // R2: error on tick cycle counts toward closing window
        window(31, 1, "R2 tick error a");
        window(31, 1, "R2 tick error b");
        check("R2 tick-cycle error counted", int'(alarm), 1);
        window(0, 0, "R11 empty a");
        window(0, 0, "R11 empty b");
        check("R11 restart clears", int'(alarm), 0);

        // R3: saturation at raise code 15 (60)
        raise_code = 4'd15;
        window(130, 0, "R3 sat a");
        window(130, 0, "R3 sat b");
        check("R3 saturated count raises", int'(alarm), 1);
        window(0, 0, "R3 drop a");
        window(0, 0, "R3 drop b");
        check("R3 cleared", int'(alarm), 0);

        // R4: raise code 0 -> 16
        raise_code = 4'd0;
        window(15, 0, "R4 15 a");
        window(15, 0, "R4 15 b");
        check("R4 below 16 stays low", int'(alarm), 0);
        window(16, 0, "R4 16 a");
        window(16, 0, "R4 16 b");
        check("R4 at 16 raises", int'(alarm), 1);
        window(0, 0, "R4 drop a");
        window(0, 0, "R4 drop b");

        // R5: clear code 7 (24) under raise 60
        raise_code = 4'd15;
        clear_code = 3'd7;
        window(60, 0, "R5 raise a");
        window(60, 0, "R5 raise b");
        window(25, 0, "R5 25 a");
        window(25, 0, "R5 25 b");
        check("R5 above 24 keeps alarm", int'(alarm), 1);
        window(24, 0, "R5 24 a");
        window(24, 0, "R5 24 b");
        check("R5 at 24 clears", int'(alarm), 0);

        // R9: clear 24 above raise 16 is ignored
        raise_code = 4'd0;
        window(20, 0, "R9 raise a");
        window(20, 0, "R9 raise b");
        window(16, 0, "R9 16 a");
        window(16, 0, "R9 16 b");
        check("R9 at raise level keeps alarm", int'(alarm), 1);
        window(15, 0, "R9 15 a");
        window(15, 0, "R9 15 b");
        check("R9 below raise clears", int'(alarm), 0);

        // R10: no ticks, lots of errors, alarm must not move
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, "R10 no tick");
        check("R10 steady without tick", int'(alarm), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule